// File: doc/BRIEF.md
# DAC Channel Toggle and Dither Sequencer

This block sits in front of one converter channel. It chooses the 16-bit code the converter sees. The inputs are the channel's two stored codes, called A and B, a 16-bit settings word, the channel's bit from the global toggle/dither enable mask, a software toggle bit and three external toggle clocks.

When the enable bit is clear, the output simply follows A. When it is set, the output moves only in response to the selected toggle source.
- In toggle mode the output alternates between A and B.
- In dither mode the output is A plus a triangular wave. B sets the wave's amplitude. The settings word sets its period in toggle-clock rising edges and its starting quarter-period phase.

All four toggle sources pass through a synchroniser before they are used. The output is registered.

Top module: `dac_wave_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `dac_code` becomes 0.
- R2: With `ch_en` low, `dac_code` equals the `code_a` of the previous clock edge. `code_b` and all toggle sources have no effect.
- R3: The select field `cfg_word[5:4]` picks the source. Value 0 picks `sw_tog`, and values 1, 2 and 3 pick `ext_tog[0]`, `ext_tog[1]` and `ext_tog[2]`. Every source passes through a two-flop synchroniser, so the output reacts at the third clock edge after the source changes. Sources that are not selected have no effect.
- R4: Toggle mode is `cfg_word[11]` = 0 with `ch_en` high. On every change of the synchronised selected source, `dac_code` loads `code_b` if the source is now high and `code_a` if it is now low.
- R5: In enabled toggle mode, changing `code_a` or `code_b` without a source change leaves `dac_code` unchanged.
- R6: Dither mode is `cfg_word[11]` = 1 with `ch_en` high and a valid period.
  - On each rising edge of the synchronised selected source, `dac_code` loads clamp(A + off(s)), then the step index s advances modulo P. Falling edges have no effect.
  - With Q = P/4, q = s/Q and r = s mod Q, off(s) depends on the quarter q:
    - q = 0: floor(amp·r/Q)
    - q = 1: floor(amp·(Q−r)/Q)
    - q = 2: −floor(amp·r/Q)
    - q = 3: −floor(amp·(Q−r)/Q)
- R7: The period field `cfg_word[8:6]` values 0 to 4 give P = 4, 8, 16, 32 or 64 steps.
- R8: The phase field `cfg_word[10:9]` value v loads the step index with v·P/4 on every clock edge where dither is not active.
- R9: The dither amplitude is `code_b[15:2]`. `code_b[1:0]` is ignored.
- R10: The dither result is clamped: sums below 0 give 0, and sums above 65535 give 65535.
- R11: In enabled dither mode with period field 5, 6 or 7, `dac_code` follows `code_a` as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_en | input | 1 | This channel's bit of the global toggle/dither enable mask |
| cfg_word | input | 16 | Channel settings: source [5:4], period [8:6], phase [10:9], dither mode [11] |
| code_a | input | 16 | A code register |
| code_b | input | 16 | B code register, or amplitude in [15:2] in dither mode |
| sw_tog | input | 1 | Software toggle bit |
| ext_tog | input | 3 | External toggle clock inputs |
| dac_code | output | 16 | Registered code presented to the converter |

## Verification
Toggle mode is driven with every source value while the unselected sources are kept busy. This separates correct source decoding from a crossed mux leg, and it separates edge-driven loading from a plain level follow of A or B. Dither mode is swept over all five periods and all four start phases, each run covering a full period plus wrap. This exposes errors in the quarter decode, the fold-back (Q−r) term and the modulo wrap. Three amplitude and base pairs are used: mid-range, one that underflows below zero and one that overflows above full scale. These tell the clamp edges apart from the plain sum, and one of them carries set low B bits to confirm those bits are dropped. Invalid period codes and the disabled state are checked for a direct follow of A while the sources move.

// File: rtl/dws_pkg.sv
package dws_pkg;

  // Settings word layout; field positions are decoded by this block
  typedef struct packed {
    logic [3:0] rsv_hi;   // [15:12]
    logic       dith;     // [11]
    logic [1:0] phase;    // [10:9]
    logic [2:0] per;      // [8:6]
    logic [1:0] src;      // [5:4]
    logic [3:0] rsv_lo;   // [3:0]
  } cfg_t;

  function automatic logic per_valid(input logic [2:0] per, input int max_per);
    return int'(per) <= max_per;
  endfunction

endpackage

// File: rtl/dws_src_sync.sv
module dws_src_sync #(
  parameter int NEXT        = 3,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NEXT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sw_tog,
  input  logic [NEXT-1:0]  ext_tog,
  input  logic [SEL_W-1:0] src_sel,
  output logic             lvl,
  output logic             chg,
  output logic             rise
);

  logic [NEXT:0] raw;
  logic [NEXT:0] synced;
  logic          prev_q;

  assign raw = {ext_tog, sw_tog};

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      logic [SYNC_STAGES-1:0][NEXT:0] stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= {stg_q[SYNC_STAGES-2:0], raw};
      end
      assign synced = stg_q[SYNC_STAGES-1];
    end else begin : g_single
      logic [NEXT:0] stg_q;
      always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= raw;
      end
      assign synced = stg_q;
    end
  endgenerate

  assign lvl = (int'(src_sel) <= NEXT) ? synced[src_sel] : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  assign chg  = lvl ^ prev_q;
  assign rise = lvl & ~prev_q;

  // R3: a rising edge is a single-cycle event for a steady source choice
  // R3
  single_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rise && $stable(src_sel) |=> !rise);

endmodule

// File: rtl/dws_tri_gen.sv
module dws_tri_gen #(
  parameter int CODE_W  = 16,
  parameter int MAX_PER = 4,
  localparam int AW     = CODE_W - 2,
  localparam int PH_W   = MAX_PER + 2,
  localparam int PR_W   = AW + PH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              step,
  input  logic [1:0]        phase,
  input  logic [2:0]        per,
  input  logic [CODE_W-1:0] code_a,
  input  logic [AW-1:0]     amp,
  output logic [CODE_W-1:0] tri_val
);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] qlen;
  logic [PH_W-1:0] pmask;
  logic [PH_W-1:0] rem;
  logic [PH_W-1:0] qidx;
  logic [PH_W-1:0] rr;
  logic [PR_W-1:0] prod;
  logic [AW-1:0]   mag;
  logic signed [CODE_W+1:0] sum;

  assign qlen  = PH_W'(1) << per;
  assign pmask = (PH_W'(4) << per) - PH_W'(1);
  assign rem   = ph_q & (qlen - PH_W'(1));
  assign qidx  = (ph_q & pmask) >> per;
  assign rr    = qidx[0] ? (qlen - rem) : rem;
  assign prod  = PR_W'(amp) * PR_W'(rr);
  assign mag   = AW'(prod >> per);

  always_comb begin
    if (qidx[1]) sum = $signed({2'b00, code_a}) - $signed({4'b0000, mag});
    else         sum = $signed({2'b00, code_a}) + $signed({4'b0000, mag});
    if (sum[CODE_W+1])   tri_val = '0;
    else if (sum[CODE_W]) tri_val = '1;
    else                 tri_val = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          ph_q <= '0;
    else if (!active) ph_q <= PH_W'(phase) << per;
    else if (step)    ph_q <= (ph_q + PH_W'(1)) & pmask;
  end

  // R8: first step after activation starts from the selected quarter
  // R8
  start_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!active) && active && $stable(per) |-> (ph_q >> per) == PH_W'(phase));

endmodule

// File: rtl/dac_wave_seq.sv
module dac_wave_seq #(
  parameter int CODE_W      = 16,
  parameter int NEXT        = 3,
  parameter int SYNC_STAGES = 2,
  parameter int MAX_PER     = 4,
  localparam int AW         = CODE_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ch_en,
  input  logic [15:0]       cfg_word,
  input  logic [CODE_W-1:0] code_a,
  input  logic [CODE_W-1:0] code_b,
  input  logic              sw_tog,
  input  logic [NEXT-1:0]   ext_tog,
  output logic [CODE_W-1:0] dac_code
);

  import dws_pkg::*;

  localparam int SEL_W = $clog2(NEXT + 1);

  cfg_t            cfg;
  logic            per_ok;
  logic            dith_act;
  logic            src_lvl;
  logic            src_chg;
  logic            src_rise;
  logic [CODE_W-1:0] tri_val;

  assign cfg      = cfg_t'(cfg_word);
  assign per_ok   = per_valid(cfg.per, MAX_PER);
  assign dith_act = ch_en & cfg.dith & per_ok;

  dws_src_sync #(
    .NEXT(NEXT), .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk(clk), .rst(rst), .sw_tog(sw_tog), .ext_tog(ext_tog),
    .src_sel(SEL_W'(cfg.src)), .lvl(src_lvl), .chg(src_chg), .rise(src_rise)
  );

  dws_tri_gen #(
    .CODE_W(CODE_W), .MAX_PER(MAX_PER)
  ) u_tri (
    .clk(clk), .rst(rst), .active(dith_act), .step(src_rise),
    .phase(cfg.phase), .per(cfg.per), .code_a(code_a),
    .amp(code_b[CODE_W-1:2]), .tri_val(tri_val)
  );

  always_ff @(posedge clk) begin
    if (rst)                                dac_code <= '0;
    else if (!ch_en || (cfg.dith && !per_ok)) dac_code <= code_a;
    else if (cfg.dith) begin
      if (src_rise) dac_code <= tri_val;
    end else if (src_chg) dac_code <= src_lvl ? code_b : code_a;
  end

  // R2
  follow_a_chk: assert property (@(posedge clk) disable iff (rst)
    !ch_en |=> dac_code == $past(code_a));

  // R5
  tog_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ch_en && !cfg.dith && !src_chg |=> $stable(dac_code));

  // R6
  dith_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dith_act && !src_rise |=> $stable(dac_code));

  // R10
  dith_bound_chk: assert property (@(posedge clk) disable iff (rst)
    dith_act && src_rise |=>
      (int'(dac_code) <= int'($past(code_a)) + int'($past(code_b[CODE_W-1:2]))) &&
      (int'(dac_code) + int'($past(code_b[CODE_W-1:2])) >= int'($past(code_a))));

  // R11
  bad_per_chk: assert property (@(posedge clk) disable iff (rst)
    ch_en && cfg.dith && !per_ok |=> dac_code == $past(code_a));

endmodule

// File: tb/dac_wave_seq_tb.sv
`timescale 1ns/1ps
module dac_wave_seq_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ch_en = 1'b0;
  logic [15:0] cfg_word = '0;
  logic [15:0] code_a = '0;
  logic [15:0] code_b = '0;
  logic        sw_tog = 1'b0;
  logic [2:0]  ext_tog = '0;
  logic [15:0] dac_code;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dac_wave_seq u_dut (
    .clk(clk), .rst(rst), .ch_en(ch_en), .cfg_word(cfg_word),
    .code_a(code_a), .code_b(code_b), .sw_tog(sw_tog),
    .ext_tog(ext_tog), .dac_code(dac_code)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] exp);
    n_run++;
    if (dac_code !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, dac_code, exp);
    end
  endtask

  function automatic logic [15:0] mk_cfg(input bit dith, input int ph,
                                         input int per, input int src);
    return {4'b0000, dith, 2'(ph), 3'(per), 2'(src), 4'b0000};
  endfunction

  function automatic int tri_off(input int amp, input int pc, input int s);
    int q, r, qq;
    qq = 1 << pc;
    q  = s / qq;
    r  = s % qq;
    case (q)
      0: return amp * r / qq;
      1: return amp * (qq - r) / qq;
      2: return -(amp * r / qq);
      default: return -(amp * (qq - r) / qq);
    endcase
  endfunction

  function automatic logic [15:0] clamp16(input int v);
    if (v < 0) return 16'd0;
    if (v > 65535) return 16'hFFFF;
    return 16'(v);
  endfunction

  task automatic set_src(input int src, input bit v);
    if (src == 0) sw_tog = v;
    else ext_tog[src-1] = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int base_a[3];
    int base_b[3];
    tick(3);
    chk("R1 reset", 16'h0000);
    rst = 0;

    // R2: disabled follows A, B and sources ignored
    foreach (base_a[i]) base_a[i] = 0;
    for (int k = 0; k < 4; k++) begin
      code_a = 16'h1111 * (k + 1) + 16'(k);
      code_b = ~code_a;
      sw_tog = k[0];
      ext_tog = 3'(k * 3);
      tick(4);
      chk("R2 disabled follow", code_a);
    end
    sw_tog = 0; ext_tog = '0;

    // R3/R4/R5 toggle mode for each source
    for (int src = 0; src < 4; src++) begin
      ch_en = 0;
      cfg_word = mk_cfg(0, 0, 0, src);
      code_a = 16'h0A00 + 16'(src);
      code_b = 16'hB000 + 16'(src);
      tick(4);
      ch_en = 1;
      tick(4);
      chk("R4 toggle start holds A", code_a);
      for (int o = 0; o < 4; o++) if (o != src) set_src(o, 1);
      tick(4);
      chk("R3 unselected ignored", code_a);
      set_src(src, 1);
      tick(4);
      chk("R4 source high gives B", code_b);
      code_b = 16'h5555;
      tick(4);
      chk("R5 B write held", 16'hB000 + 16'(src));
      for (int o = 0; o < 4; o++) if (o != src) set_src(o, 0);
      set_src(src, 0);
      tick(4);
      chk("R4 source low gives A", code_a);
      code_a = 16'h7777;
      tick(4);
      chk("R5 A write held", 16'h0A00 + 16'(src));
      set_src(src, 1);
      tick(4);
      chk("R4 new B after edge", 16'h5555);
      set_src(src, 0);
      tick(4);
      chk("R4 new A after edge", 16'h7777);
    end

    // R11 invalid period codes
    for (int pc = 5; pc < 8; pc++) begin
      ch_en = 1;
      cfg_word = mk_cfg(1, 1, pc, 1);
      code_a = 16'(pc * 1000);
      ext_tog[0] = pc[0];
      tick(4);
      chk("R11 invalid period follows A", code_a);
    end
    ext_tog = '0;

    // R6..R10 dither sweep
    base_a[0] = 30000; base_b[0] = 16'h1234 | 3;
    base_a[1] = 100;   base_b[1] = 16'hFFFF;
    base_a[2] = 65000; base_b[2] = 16'hFFFC;
    for (int c = 0; c < 3; c++) begin
      for (int pc = 0; pc < 5; pc++) begin
        for (int ph = 0; ph < 4; ph++) begin
          int p, s, amp, src;
          logic [15:0] e;
          p = 4 << pc;
          src = c + 1;
          amp = base_b[c] >> 2;
          ch_en = 0;
          sw_tog = 0; ext_tog = '0;
          code_a = 16'(base_a[c]);
          code_b = 16'(base_b[c]);
          cfg_word = mk_cfg(1, ph, pc, src);
          tick(4);
          ch_en = 1;
          tick(4);
          chk("R8 dither entry holds A", code_a);
          s = ph * (p / 4);
          for (int st = 0; st < p + 2; st++) begin
            e = clamp16(base_a[c] + tri_off(amp, pc, s));
            set_src(src, 1);
            tick(4);
            chk("R6 R7 R9 R10 dither step", e);
            set_src(src, 0);
            tick(4);
            chk("R6 falling edge ignored", e);
            s = (s + 1) % p;
          end
        end
      end
    end

    ch_en = 0;
    code_a = 16'h4321;
    tick(3);
    chk("R2 disable after dither", 16'h4321);
    finish_run();
  end

endmodule